// File: doc/BRIEF.md
# Transmit Descriptor Fetch and Write-Back Scheduler

This block sits beside a transmit DMA engine and decides, each cycle, whether the engine should pull more descriptors from host memory and whether it should return processed descriptors to host memory. It keeps three running counts. The first is unprocessed descriptors held in the on-chip ring. The second is valid descriptors that software has posted in host memory but that have not yet been fetched. The third is processed descriptors that wait in the ring to be written back. A 32-bit control word sets three thresholds and a unit-select bit.

A fetch is raised only when three things hold together: the ring runs low, host memory holds enough descriptors, and no more urgent DMA work is pending. The fetch size is the smaller of the host count and the free ring space. The engine acknowledges it with a grant pulse, and the counts move on that pulse. Write-backs are gathered into batches against the third threshold. A flush input drains every processed descriptor at once.

Top module: `txdesc_sched`

## Requirements
- R1: After reset the control word reads 0, no fetch or write-back request is raised, and all three counts are zero.
- R2: Control bits outside the used fields (bits 7:6, 15:14, 23:22 and 31:25) always read as zero. Writing 0xFFFFFFFF reads back 0x013F3F3F.
- R3: A fetch is requested only while the on-chip unprocessed count is strictly below the effective prefetch threshold (control bits 5:0).
- R4: A fetch is requested only while the host count is at least the effective host threshold (control bits 13:8) and is at least one.
- R5: No fetch is requested while `hi_pri_pend` is high, while an earlier fetch still waits for its grant, or in a cycle that issues a write-back.
- R6: Without a flush, a write-back is issued only once the ready count is strictly greater than the effective write-back threshold (control bits 21:16). It carries the whole ready count.
- R7: With a write-back threshold of zero, each processed descriptor is written back with a count of 1 on the clock edge after the edge that recorded it.
- R8: A `flush_req` sampled while the ready count is non-zero issues a write-back of the whole ready count on that edge, whatever the threshold. A flush with nothing ready issues nothing.
- R9: Control bit 24 = 1 makes all thresholds count descriptors. Bit 24 = 0 multiplies each threshold by DPL (default 4 descriptors per cache line) before it is compared.
- R10: The fetch count equals min(host count, DEPTH − on-chip − ready). A `fetch_gnt` pulse moves that count from the host count to the on-chip count. The on-chip count plus the ready count never exceeds DEPTH.
- R11: `fetch_req` and `wb_req` are registered one-cycle pulses. Each appears on the edge that samples its condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the control word |
| cfg_wr_data | input | 32 | Control word write data |
| cfg_rd_data | output | 32 | Control word read-back |
| host_add_en | input | 1 | Software posted new descriptors in host memory |
| host_add_num | input | HOST_W | Number of descriptors posted |
| proc_done | input | 1 | One on-chip descriptor finished processing |
| flush_req | input | 1 | Force write-back of all ready descriptors |
| hi_pri_pend | input | 1 | More urgent DMA activity is pending |
| fetch_gnt | input | 1 | DMA engine accepted the outstanding fetch |
| fetch_req | output | 1 | One-cycle descriptor fetch request |
| fetch_num | output | CNT_W | Descriptors to fetch |
| wb_req | output | 1 | One-cycle write-back request |
| wb_num | output | CNT_W | Descriptors to write back |

## Verification
The fetch decision is exercised with host counts just below and exactly at the host threshold, which isolates the inclusive comparison. A zero host threshold with zero and then one posted descriptor shows the minimum-of-one rule. Ring fill levels just below and at the prefetch threshold separate the strict-below test. Holding the priority flag, or leaving a fetch ungranted, shows that both inhibit fetches. A large host posting against a nearly full ring tells a size capped by free space from a size taken from the host count. On the write-back side, runs of processed descriptors that stop one short of the threshold and then pass it show the strict-greater rule. Flushes with and without ready descriptors are both applied. Repeating both decisions in cache-line units with raw values that would give the opposite answer in descriptor units shows that the scaling is applied.

// File: rtl/txds_pkg.sv
package txds_pkg;

  localparam int FLD_W = 6;

  // Writable bits of the control word; everything else reads as zero.
  localparam logic [31:0] CFG_WMASK = 32'h013F_3F3F;

  typedef struct packed {
    logic             unit_desc;  // 1: descriptor units, 0: cache-line units
    logic [FLD_W-1:0] wb_thr;
    logic [FLD_W-1:0] host_thr;
    logic [FLD_W-1:0] pf_thr;
  } txds_cfg_t;

  function automatic txds_cfg_t unpack_cfg(input logic [31:0] w);
    txds_cfg_t c;
    c.pf_thr    = w[5:0];
    c.host_thr  = w[13:8];
    c.wb_thr    = w[21:16];
    c.unit_desc = w[24];
    return c;
  endfunction

  function automatic logic [31:0] pack_cfg(input txds_cfg_t c);
    logic [31:0] w;
    w        = '0;
    w[5:0]   = c.pf_thr;
    w[13:8]  = c.host_thr;
    w[21:16] = c.wb_thr;
    w[24]    = c.unit_desc;
    return w;
  endfunction

  // Smaller of two unsigned values.
  function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction

  // Host threshold with the at-least-one floor.
  function automatic int unsigned host_need(input int unsigned thr);
    return (thr == 0) ? 1 : thr;
  endfunction

endpackage

// File: rtl/txds_cfg_reg.sv
module txds_cfg_reg
  import txds_pkg::*;
#(
  parameter int DPL  = 4,
  parameter int TH_W = FLD_W + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [31:0]     wr_data,
  output logic [31:0]     rd_data,
  output logic [TH_W-1:0] pf_eff,
  output logic [TH_W-1:0] host_eff,
  output logic [TH_W-1:0] wb_eff
);

  localparam int  LOG_DPL = (DPL > 1) ? $clog2(DPL) : 0;
  localparam bit  DPL_P2  = ((DPL & (DPL - 1)) == 0);

  txds_cfg_t        cfg_q;
  logic [FLD_W-1:0] fld [3];
  logic [TH_W-1:0]  eff [3];

  always_ff @(posedge clk) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= unpack_cfg(wr_data);
  end

  assign rd_data = pack_cfg(cfg_q);

  assign fld[0] = cfg_q.pf_thr;
  assign fld[1] = cfg_q.host_thr;
  assign fld[2] = cfg_q.wb_thr;

  for (genvar i = 0; i < 3; i++) begin : g_scale
    if (DPL_P2) begin : g_shift
      assign eff[i] = cfg_q.unit_desc ? TH_W'(fld[i])
                                      : (TH_W'(fld[i]) << LOG_DPL);
    end else begin : g_mult
      assign eff[i] = cfg_q.unit_desc ? TH_W'(fld[i])
                                      : TH_W'(fld[i]) * TH_W'(DPL);
    end
  end

  assign pf_eff   = eff[0];
  assign host_eff = eff[1];
  assign wb_eff   = eff[2];

endmodule

// File: rtl/txds_fetch_ctl.sv
module txds_fetch_ctl
  import txds_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 7,
  parameter int HOST_W = 16,
  parameter int TH_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_add_en,
  input  logic [HOST_W-1:0] host_add_num,
  input  logic              proc_done,
  input  logic              fetch_gnt,
  input  logic              hi_pri_pend,
  input  logic              wb_fire,
  input  logic [CNT_W-1:0]  wb_cnt,
  input  logic [TH_W-1:0]   pf_eff,
  input  logic [TH_W-1:0]   host_eff,
  output logic              fetch_req,
  output logic [CNT_W-1:0]  fetch_num,
  output logic              fetch_fire,
  output logic              fetch_busy,
  output logic              proc_take,
  output logic [CNT_W-1:0]  on_cnt,
  output logic [HOST_W-1:0] host_cnt
);

  logic [CNT_W-1:0] free_slots;
  logic [CNT_W-1:0] fetch_amt;
  logic             ring_low;
  logic             host_ready;
  logic             gnt_take;

  assign free_slots = CNT_W'(DEPTH) - on_cnt - wb_cnt;
  assign fetch_amt  = CNT_W'(min_u(32'(host_cnt), 32'(free_slots)));
  assign ring_low   = 32'(on_cnt) < 32'(pf_eff);
  assign host_ready = 32'(host_cnt) >= host_need(32'(host_eff));
  assign gnt_take   = fetch_gnt && fetch_busy;
  assign proc_take  = proc_done && (on_cnt != '0);

  assign fetch_fire = ring_low && host_ready && (free_slots != '0)
                   && !hi_pri_pend && !fetch_busy && !wb_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_req  <= 1'b0;
      fetch_num  <= '0;
      fetch_busy <= 1'b0;
    end else begin
      fetch_req <= fetch_fire;
      if (fetch_fire) begin
        fetch_num  <= fetch_amt;
        fetch_busy <= 1'b1;
      end else if (gnt_take) begin
        fetch_busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_cnt   <= '0;
      host_cnt <= '0;
    end else begin
      on_cnt   <= on_cnt + (gnt_take ? fetch_num : '0)
                         - (proc_take ? CNT_W'(1) : '0);
      host_cnt <= host_cnt + (host_add_en ? host_add_num : '0)
                           - (gnt_take ? HOST_W'(fetch_num) : '0);
    end
  end

endmodule

// File: rtl/txds_wb_ctl.sv
module txds_wb_ctl #(
  parameter int CNT_W = 7,
  parameter int TH_W  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             proc_take,
  input  logic             flush_req,
  input  logic [TH_W-1:0]  wb_eff,
  output logic             wb_req,
  output logic [CNT_W-1:0] wb_num,
  output logic             wb_fire,
  output logic [CNT_W-1:0] wb_cnt
);

  logic batch_full;
  logic flush_hit;

  assign batch_full = 32'(wb_cnt) > 32'(wb_eff);
  assign flush_hit  = flush_req && (wb_cnt != '0);
  assign wb_fire    = batch_full || flush_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_req <= 1'b0;
      wb_num <= '0;
      wb_cnt <= '0;
    end else begin
      wb_req <= wb_fire;
      if (wb_fire) wb_num <= wb_cnt;
      wb_cnt <= (wb_fire ? '0 : wb_cnt) + (proc_take ? CNT_W'(1) : '0);
    end
  end

endmodule

// File: rtl/txdesc_sched.sv
module txdesc_sched
  import txds_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int HOST_W = 16,
  parameter int DPL    = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [31:0]       cfg_wr_data,
  output logic [31:0]       cfg_rd_data,
  input  logic              host_add_en,
  input  logic [HOST_W-1:0] host_add_num,
  input  logic              proc_done,
  input  logic              flush_req,
  input  logic              hi_pri_pend,
  input  logic              fetch_gnt,
  output logic              fetch_req,
  output logic [CNT_W-1:0]  fetch_num,
  output logic              wb_req,
  output logic [CNT_W-1:0]  wb_num
);

  localparam int TH_W = FLD_W + ((DPL > 1) ? $clog2(DPL) : 0) + 1;

  logic [TH_W-1:0]   pf_eff, host_eff, wb_eff;
  logic              fetch_fire, fetch_busy, wb_fire, proc_take;
  logic [CNT_W-1:0]  on_cnt, wb_cnt;
  logic [HOST_W-1:0] host_cnt;

  txds_cfg_reg #(.DPL(DPL), .TH_W(TH_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .rd_data(cfg_rd_data), .pf_eff(pf_eff), .host_eff(host_eff), .wb_eff(wb_eff)
  );

  txds_fetch_ctl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .HOST_W(HOST_W), .TH_W(TH_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .host_add_en(host_add_en), .host_add_num(host_add_num),
    .proc_done(proc_done), .fetch_gnt(fetch_gnt), .hi_pri_pend(hi_pri_pend),
    .wb_fire(wb_fire), .wb_cnt(wb_cnt), .pf_eff(pf_eff), .host_eff(host_eff),
    .fetch_req(fetch_req), .fetch_num(fetch_num), .fetch_fire(fetch_fire),
    .fetch_busy(fetch_busy), .proc_take(proc_take), .on_cnt(on_cnt), .host_cnt(host_cnt)
  );

  txds_wb_ctl #(.CNT_W(CNT_W), .TH_W(TH_W)) u_wb (
    .clk(clk), .rst_n(rst_n), .proc_take(proc_take), .flush_req(flush_req),
    .wb_eff(wb_eff), .wb_req(wb_req), .wb_num(wb_num), .wb_fire(wb_fire), .wb_cnt(wb_cnt)
  );

endmodule

// File: rtl/txds_sched_chk.sv
module txds_sched_chk #(
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 7,
  parameter int HOST_W = 16,
  parameter int TH_W   = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       cfg_rd_data,
  input logic              flush_req,
  input logic              hi_pri_pend,
  input logic              fetch_req,
  input logic [CNT_W-1:0]  fetch_num,
  input logic              wb_req,
  input logic [CNT_W-1:0]  wb_num,
  input logic              wb_fire,
  input logic [CNT_W-1:0]  on_cnt,
  input logic [CNT_W-1:0]  wb_cnt,
  input logic [HOST_W-1:0] host_cnt,
  input logic [TH_W-1:0]   pf_eff,
  input logic [TH_W-1:0]   host_eff,
  input logic [TH_W-1:0]   wb_eff
);

  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data & ~32'h013F_3F3F) == 32'h0);

  p_fetch_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> 32'($past(on_cnt)) < 32'($past(pf_eff)));

  p_fetch_host_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> ($past(host_cnt) != '0) && (32'($past(host_cnt)) >= 32'($past(host_eff))));

  p_fetch_yield_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> !$past(hi_pri_pend) && !$past(wb_fire));

  p_wb_batch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !$past(flush_req)) |-> 32'($past(wb_cnt)) > 32'($past(wb_eff)));

  p_flush_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && wb_cnt != '0) |=> wb_req && (wb_num == $past(wb_cnt)));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    32'(on_cnt) + 32'(wb_cnt) <= DEPTH);

  p_fetch_size_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> (fetch_num != '0) && (32'(fetch_num) <= 32'($past(host_cnt))));

  p_fetch_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> !fetch_req);

endmodule

bind txdesc_sched txds_sched_chk #(
  .DEPTH(DEPTH), .CNT_W(CNT_W), .HOST_W(HOST_W), .TH_W(TH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rd_data(cfg_rd_data), .flush_req(flush_req),
  .hi_pri_pend(hi_pri_pend), .fetch_req(fetch_req), .fetch_num(fetch_num),
  .wb_req(wb_req), .wb_num(wb_num), .wb_fire(wb_fire), .on_cnt(on_cnt),
  .wb_cnt(wb_cnt), .host_cnt(host_cnt), .pf_eff(pf_eff), .host_eff(host_eff),
  .wb_eff(wb_eff)
);

// File: tb/sim_txdesc_sched.sv
`timescale 1ns/1ps
module sim_txdesc_sched;

  localparam int CNT_W = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic        host_add_en = 1'b0;
  logic [15:0] host_add_num = '0;
  logic        proc_done = 1'b0;
  logic        flush_req = 1'b0;
  logic        hi_pri_pend = 1'b0;
  logic        fetch_gnt = 1'b0;
  logic        fetch_req;
  logic [CNT_W-1:0] fetch_num;
  logic        wb_req;
  logic [CNT_W-1:0] wb_num;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  txdesc_sched u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .host_add_en(host_add_en), .host_add_num(host_add_num),
    .proc_done(proc_done), .flush_req(flush_req), .hi_pri_pend(hi_pri_pend),
    .fetch_gnt(fetch_gnt), .fetch_req(fetch_req), .fetch_num(fetch_num),
    .wb_req(wb_req), .wb_num(wb_num)
  );

  task automatic check(input string req, input int unsigned act, input int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic [31:0] d);
    cfg_wr_en = 1'b1; cfg_wr_data = d; step(); cfg_wr_en = 1'b0;
  endtask

  task automatic add_host(input int n);
    host_add_en = 1'b1; host_add_num = 16'(n); step(); host_add_en = 1'b0;
  endtask

  task automatic grant();
    fetch_gnt = 1'b1; step(); fetch_gnt = 1'b0;
  endtask

  task automatic expect_fetch(input string req, input int n);
    check({req, " fetch_req"}, fetch_req, 1);
    check({req, " fetch_num"}, fetch_num, n);
  endtask

  task automatic expect_wb(input string req, input int n);
    check({req, " wb_req"}, wb_req, 1);
    check({req, " wb_num"}, wb_num, n);
  endtask

  // R1: reset state
  task automatic t_reset();
    check("R1 cfg", cfg_rd_data, 0);
    check("R1 fetch_req", fetch_req, 0);
    check("R1 wb_req", wb_req, 0);
    step();
    check("R1 idle fetch", fetch_req, 0);
  endtask

  // R2: reserved bits read zero
  task automatic t_reserved();
    write_cfg(32'hFFFF_FFFF);
    check("R2 readback", cfg_rd_data, 32'h013F_3F3F);
    write_cfg(32'h0);
    check("R2 clear", cfg_rd_data, 0);
  endtask

  // R3 R4 R5 R7 R10 R11: basic fetch, immediate write-back, priority hold
  task automatic t_fetch_basic();
    hi_pri_pend = 1'b1;
    write_cfg(32'h0100_0408);          // unit=desc, host_thr=4, pf_thr=8
    add_host(10);
    hi_pri_pend = 1'b0; step();
    expect_fetch("R10", 10);
    step();
    check("R11 pulse", fetch_req, 0);
    grant();                           // on=10 host=0
    hi_pri_pend = 1'b1;
    add_host(5);
    for (int i = 0; i < 3; i++) begin
      proc_done = 1'b1; step(); proc_done = 1'b0;
      check("R7 not yet", wb_req, 0);
      step();
      expect_wb("R7", 1);
    end
    check("R5 hi_pri holds fetch", fetch_req, 0);
    hi_pri_pend = 1'b0; step();
    expect_fetch("R3", 5);             // on=7 < 8
    grant();                           // on=12
  endtask

  // R4: host threshold boundary and zero-threshold floor
  task automatic t_host_thr();
    hi_pri_pend = 1'b1;
    write_cfg(32'h0100_0410);          // pf_thr=16 host_thr=4
    add_host(3);
    hi_pri_pend = 1'b0; step();
    check("R4 host 3 < 4", fetch_req, 0);
    add_host(1);
    check("R4 host 3 at edge", fetch_req, 0);
    step();
    expect_fetch("R4 host 4", 4);
    grant();                           // on=16
    write_cfg(32'h0100_0014);          // pf_thr=20 host_thr=0
    step();
    check("R4 zero host", fetch_req, 0);
    add_host(1);
    check("R4 host at add edge", fetch_req, 0);
    step();
    expect_fetch("R4 floor one", 1);
  endtask

  // R5: outstanding fetch blocks another
  task automatic t_outstanding();
    add_host(2);
    check("R5 busy", fetch_req, 0);
    step(); check("R5 busy", fetch_req, 0);
    step(); check("R5 busy", fetch_req, 0);
    grant();                           // on=17 host=2
    check("R5 grant edge", fetch_req, 0);
    step();
    expect_fetch("R5 after grant", 2);
    grant();                           // on=19
  endtask

  // R10: fetch capped by free ring space
  task automatic t_cap();
    hi_pri_pend = 1'b1;
    write_cfg(32'h0100_003F);          // pf_thr=63 host_thr=0
    add_host(60);
    hi_pri_pend = 1'b0; step();
    expect_fetch("R10 cap", 45);
    grant();                           // on=64 host=15
    step();
    check("R10 full ring", fetch_req, 0);
  endtask

  // R6: batched write-back
  task automatic t_batch();
    write_cfg(32'h0103_0000);          // unit=desc wb_thr=3, pf_thr=0
    for (int i = 0; i < 4; i++) begin
      proc_done = 1'b1; step();
      check("R6 below batch", wb_req, 0);
    end
    proc_done = 1'b0; step();
    expect_wb("R6", 4);
    step();
    check("R11 wb pulse", wb_req, 0);
  endtask

  // R8: flush
  task automatic t_flush();
    proc_done = 1'b1; step(); step(); proc_done = 1'b0;
    step();
    check("R8 no wb before flush", wb_req, 0);
    flush_req = 1'b1; step(); flush_req = 1'b0;
    expect_wb("R8", 2);
    flush_req = 1'b1; step(); flush_req = 1'b0;
    check("R8 empty flush", wb_req, 0);
  endtask

  // R9: cache-line units
  task automatic t_gran();
    write_cfg(32'h0001_0000);          // cache-line units, wb_thr=1 -> 4
    for (int i = 0; i < 5; i++) begin
      proc_done = 1'b1; step();
      check("R9 wb scaled", wb_req, 0);
    end
    proc_done = 1'b0; step();
    expect_wb("R9", 5);                // on=53 host=15
    write_cfg(32'h0000_040F);          // host_thr 4 -> 16, pf_thr 15 -> 60
    step();
    check("R9 host scaled", fetch_req, 0);
    write_cfg(32'h0000_030F);          // host_thr 3 -> 12
    step();
    expect_fetch("R9 pf scaled", 11);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_reserved();
    t_fetch_basic();
    t_host_thr();
    t_outstanding();
    t_cap();
    t_batch();
    t_flush();
    t_gran();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule